// File: doc/BRIEF.md
# Compare Output Waveform Generator

This block is one compare channel of a timer. It watches the count value of a shared base counter and drives one registered waveform pin from it. On every counter tick it compares the count with its own compare value. A compare event, the base counter's period event, or both, then change the pin according to one of eight output modes. The block also gives a one-clock match pulse and a sticky compare flag, which a software clear input resets.

The base counter sits outside the block. It supplies the count, a tick enable that marks the cycles in which the count is valid for comparison, and a period-match signal. A compare event is qualified by the tick. So is a period event. In every cycle without a tick the pin holds, except in the software-driven mode. The same channel logic works whether the base counter counts up and wraps, or counts up and then down.

Top module: `cmp_wave_gen`

## Requirements
- R1: `cmp_hit` is high for exactly the one clock that follows a cycle in which `tick_en` is 1 and `cnt_val` equals `cmp_val`. It is low after every other cycle.
- R2: `cmp_flag` rises together with `cmp_hit` and stays high. It clears one clock after a cycle with `flag_clr` high, unless a compare event occurs in that same cycle, in which case it stays set.
- R3: In mode 3'b000, `wave_out` takes the value of `sw_out` one clock later, and compare and period events have no effect.
- R4: In mode 3'b001, a compare event sets `wave_out`. The pin then stays high while the mode is unchanged.
- R5: In mode 3'b010, a compare event toggles `wave_out` and a period event clears it.
- R6: In mode 3'b011, a compare event sets `wave_out` and a period event clears it.
- R7: In mode 3'b100, a compare event toggles `wave_out` and a period event does nothing, so the output period is twice the counter period.
- R8: In mode 3'b101, a compare event clears `wave_out`. The pin then stays low while the mode is unchanged.
- R9: In mode 3'b110, a compare event toggles `wave_out` and a period event sets it.
- R10: In mode 3'b111, a compare event clears `wave_out` and a period event sets it.
- R11: When a compare event and a period event fall in the same tick, the mode's period action is applied and the compare action is dropped.
- R12: In modes other than 3'b000, `wave_out` does not change after a cycle in which `tick_en` is 0, even if `period_hit` is high or the count equals the compare value.
- R13: While `rst` is high, `wave_out`, `cmp_hit` and `cmp_flag` are 0 at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count valid / counter advances this cycle |
| cnt_val | input | CNT_W | Base counter value |
| period_hit | input | 1 | Base counter at its period value |
| cmp_val | input | CNT_W | Channel compare value |
| out_mode | input | 3 | Output mode select |
| sw_out | input | 1 | Software output level for mode 0 |
| flag_clr | input | 1 | Clears the compare flag |
| cmp_hit | output | 1 | Registered compare-match pulse |
| wave_out | output | 1 | Registered waveform output |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
A behavioural counter runs in wrap-around mode and in up/down mode, with a tick on every second cycle. Each of the eight modes is tried against it. In up/down mode the compare value is passed twice per period, and this separates the toggling modes from the set and reset modes. Setting the compare value equal to the period value puts both events in the same tick, which shows which action wins. A compare value above the period gives no match at all, so the pin and the flag must stay idle. Switching from the set mode to the reset mode without a reset shows that the level is held across the change. The idle cycles between ticks, with the period input still high, show that events are qualified by the tick.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  typedef enum logic [2:0] {
    OM_SOFT   = 3'd0,
    OM_SET    = 3'd1,
    OM_TOGCLR = 3'd2,
    OM_SETCLR = 3'd3,
    OM_TOG    = 3'd4,
    OM_CLR    = 3'd5,
    OM_TOGSET = 3'd6,
    OM_CLRSET = 3'd7
  } omode_t;

  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_SET  = 3'd1,
    ACT_CLR  = 3'd2,
    ACT_TOG  = 3'd3,
    ACT_SOFT = 3'd4
  } act_t;

endpackage

// File: rtl/cwg_match.sv
module cwg_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             flag_clr,
  output logic             cmp_ev,
  output logic             cmp_hit,
  output logic             cmp_flag
);

  assign cmp_ev = tick_en && (cnt_val == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_hit  <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      cmp_hit <= cmp_ev;
      if (cmp_ev)
        cmp_flag <= 1'b1;
      else if (flag_clr)
        cmp_flag <= 1'b0;
    end
  end

  // R1: a pulse only follows a ticked equality
  p_hit_src_r1: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |-> $past(tick_en && (cnt_val == cmp_val)));

  // R2: flag is up whenever the pulse is
  p_flag_with_hit_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |-> cmp_flag);

  // R2: clear without a new event drops the flag
  p_flag_clear_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_clr && !rst) && !cmp_hit) |-> !cmp_flag);

endmodule

// File: rtl/cwg_action.sv
module cwg_action
  import cwg_pkg::*;
(
  input  logic [2:0] out_mode,
  input  logic       cmp_ev,
  input  logic       per_ev,
  output act_t       act
);

  act_t cmp_act;
  act_t per_act;

  always_comb begin
    cmp_act = ACT_HOLD;
    per_act = ACT_HOLD;
    unique case (omode_t'(out_mode))
      OM_SOFT:   begin cmp_act = ACT_SOFT; per_act = ACT_SOFT; end
      OM_SET:    cmp_act = ACT_SET;
      OM_TOGCLR: begin cmp_act = ACT_TOG; per_act = ACT_CLR; end
      OM_SETCLR: begin cmp_act = ACT_SET; per_act = ACT_CLR; end
      OM_TOG:    cmp_act = ACT_TOG;
      OM_CLR:    cmp_act = ACT_CLR;
      OM_TOGSET: begin cmp_act = ACT_TOG; per_act = ACT_SET; end
      OM_CLRSET: begin cmp_act = ACT_CLR; per_act = ACT_SET; end
      default:   ;
    endcase
  end

  always_comb begin
    if (out_mode == OM_SOFT)
      act = ACT_SOFT;
    else if (per_ev && per_act != ACT_HOLD)
      act = per_act;
    else if (cmp_ev)
      act = cmp_act;
    else
      act = ACT_HOLD;
  end

endmodule

// File: rtl/cwg_outreg.sv
module cwg_outreg
  import cwg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  act_t act,
  input  logic sw_out,
  output logic wave_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_out <= 1'b0;
    end else begin
      unique case (act)
        ACT_SET:  wave_out <= 1'b1;
        ACT_CLR:  wave_out <= 1'b0;
        ACT_TOG:  wave_out <= ~wave_out;
        ACT_SOFT: wave_out <= sw_out;
        default:  wave_out <= wave_out;
      endcase
    end
  end

endmodule

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen
  import cwg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             period_hit,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       out_mode,
  input  logic             sw_out,
  input  logic             flag_clr,
  output logic             cmp_hit,
  output logic             wave_out,
  output logic             cmp_flag
);

  logic cmp_ev;
  logic per_ev;
  act_t act;

  assign per_ev = tick_en && period_hit;

  cwg_match #(.CNT_W(CNT_W)) match_i (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .cnt_val  (cnt_val),
    .cmp_val  (cmp_val),
    .flag_clr (flag_clr),
    .cmp_ev   (cmp_ev),
    .cmp_hit  (cmp_hit),
    .cmp_flag (cmp_flag)
  );

  cwg_action action_i (
    .out_mode (out_mode),
    .cmp_ev   (cmp_ev),
    .per_ev   (per_ev),
    .act      (act)
  );

  cwg_outreg outreg_i (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .sw_out   (sw_out),
    .wave_out (wave_out)
  );

  // R3: software mode copies the level one clock later
  p_soft_follow_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && out_mode == 3'd0) |-> (wave_out == $past(sw_out)));

  // R4: set mode never lets a high pin fall
  p_set_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && out_mode == 3'd1 && wave_out) |-> wave_out);

  // R8: reset mode never lets a low pin rise
  p_clr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && out_mode == 3'd5 && !wave_out) |-> !wave_out);

  // R11: period event in modes 2 and 3 leaves the pin low
  p_per_clr_wins_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && tick_en && period_hit &&
          (out_mode == 3'd2 || out_mode == 3'd3)) |-> !wave_out);

  // R11: period event in modes 6 and 7 leaves the pin high
  p_per_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && tick_en && period_hit &&
          (out_mode == 3'd6 || out_mode == 3'd7)) |-> wave_out);

  // R12: no tick, no change outside software mode
  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !tick_en && out_mode != 3'd0) |-> $stable(wave_out));

endmodule

// File: tb/cmp_wave_gen_tb_top.sv
module cmp_wave_gen_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         period_hit = 1'b0;
  logic [W-1:0] cmp_val = '0;
  logic [2:0]   out_mode = 3'd0;
  logic         sw_out = 1'b0;
  logic         flag_clr = 1'b0;
  logic         cmp_hit, wave_out, cmp_flag;

  always #4 clk = ~clk;

  cmp_wave_gen #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_val(cnt_val),
    .period_hit(period_hit), .cmp_val(cmp_val), .out_mode(out_mode),
    .sw_out(sw_out), .flag_clr(flag_clr), .cmp_hit(cmp_hit),
    .wave_out(wave_out), .cmp_flag(cmp_flag)
  );

  typedef struct {
    logic  w;
    logic  h;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  logic m_w = 1'b0;
  logic m_f = 1'b0;

  task automatic chk(string r, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", r, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // monitor: pops one expected item per driven cycle
  always @(posedge clk) begin : mon
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.tag, "wave_out", wave_out, e.w);
      chk("R1", "cmp_hit", cmp_hit, e.h);
      chk("R2", "cmp_flag", cmp_flag, e.f);
    end
  end

  // driver step: inputs already applied after a negedge; push expectation
  task automatic push_expect();
    exp_t e;
    logic eq, pe;
    string tg;
    eq = tick_en && (cnt_val == cmp_val);
    pe = tick_en && period_hit;
    tg = tag_of(out_mode);
    if (out_mode == 3'd0) m_w = sw_out;
    else begin
      if (!tick_en) tg = "R12";
      else if (eq && pe && out_mode != 3'd1 && out_mode != 3'd4 && out_mode != 3'd5)
        tg = "R11";
      case (out_mode)
        3'd1: if (eq) m_w = 1'b1;
        3'd2: if (pe) m_w = 1'b0; else if (eq) m_w = ~m_w;
        3'd3: if (pe) m_w = 1'b0; else if (eq) m_w = 1'b1;
        3'd4: if (eq) m_w = ~m_w;
        3'd5: if (eq) m_w = 1'b0;
        3'd6: if (pe) m_w = 1'b1; else if (eq) m_w = ~m_w;
        default: if (pe) m_w = 1'b1; else if (eq) m_w = 1'b0;
      endcase
    end
    if (eq) m_f = 1'b1;
    else if (flag_clr) m_f = 1'b0;
    e.w = m_w; e.h = eq; e.f = m_f; e.tag = tg;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick_en = 1'b0; period_hit = 1'b0; flag_clr = 1'b0; sw_out = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13", "wave_out", wave_out, 1'b0);
    chk("R13", "cmp_hit", cmp_hit, 1'b0);
    chk("R13", "cmp_flag", cmp_flag, 1'b0);
    rst = 1'b0;
    m_w = 1'b0; m_f = 1'b0;
  endtask

  // behavioural base counter, tick every second cycle
  task automatic run(bit fresh, bit updown, int per, int cmpv, logic [2:0] mode,
                     int ncyc, int clr_at);
    int  cnt;
    bit  down;
    cmp_val = cmpv[W-1:0];
    out_mode = mode;
    if (fresh) do_reset();
    cnt = 0; down = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      tick_en    = (c % 2 == 0);
      cnt_val    = cnt[W-1:0];
      period_hit = (cnt == per);
      sw_out     = ((c / 3) % 2 == 1);
      flag_clr   = (c == clr_at);
      push_expect();
      if (tick_en) begin
        if (!updown) cnt = (cnt == per) ? 0 : cnt + 1;
        else if (!down) begin
          if (cnt == per) begin down = 1; cnt = cnt - 1; end
          else cnt = cnt + 1;
        end else begin
          if (cnt == 0) begin down = 0; cnt = cnt + 1; end
          else cnt = cnt - 1;
        end
      end
    end
    @(negedge clk);
    tick_en = 1'b0; flag_clr = 1'b0;
    @(posedge clk); #3;
  endtask

  initial begin
    do_reset();
    // all modes, wrap-around counter
    for (int m = 0; m < 8; m++) run(1, 0, 9, 4, m[2:0], 64, 30);
    // all modes, up/down counter
    for (int m = 0; m < 8; m++) run(1, 1, 7, 3, m[2:0], 64, 41);
    // R11: compare equals period
    for (int m = 2; m < 8; m++) run(1, 0, 6, 6, m[2:0], 48, -1);
    // R1/R7: compare never reached
    run(1, 0, 5, 12, 3'd4, 40, 10);
    // R4 then R8 across a mode change without reset
    run(1, 0, 8, 2, 3'd1, 30, -1);
    run(0, 0, 8, 5, 3'd5, 30, -1);
    // R2: clear requested in the same cycle as a compare event
    run(1, 0, 9, 0, 3'd4, 40, 20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule